// File: doc/BRIEF.md
# Interprocessor Mailbox Channel Controller

This block is a register-mapped mailbox that connects a local processor to remote processors through a set of independent channels. The local side claims a channel by writing its own one-hot vector bit into the channel's owner register. It fills an eight-word payload, picks which remote interrupt line to fire, and then starts the transfer. The remote side answers on a per-channel acknowledge input. In automatic-acknowledge mode that answer raises an interrupt back to the local side on the owner's vector. The local side clears the acknowledge to make the channel ready again, or writes zero to the owner register to give the channel up.

All channel writes are protected by a global key lock. The lock opens only when a fixed 32-bit key is written to its register, and any other value written there closes it again. Reads work whether the lock is open or closed. The bus is a plain single-cycle register port: a write takes effect at the clock edge, and read data is combinational from the address.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset every channel is idle (status word reads 0x10), its owner and target registers read 0, its mask reads all ones over the vector width, the lock register reads 1, and both interrupt vectors are 0.
- R2: The lock register at byte address 0xA00 reads 0 after 0x1ACCE551 is written and reads 1 after any other value is written. While the lock reads 1, writes to channel registers leave them unchanged.
- R3: Each channel has a 64-byte window at channel×0x40, with word offsets owner 0x00, target 0x04, target-clear 0x08, pending 0x0C, status 0x10, mask 0x14, ack-clear 0x18, start 0x1C. Writing a nonzero vector to the owner register of an idle channel stores it and makes the channel ready (status bit 5). An owner write to a channel that is not idle is ignored.
- R4: Writing zero to the owner register returns the channel to idle from any state, with the owner cleared and that channel's interrupts withdrawn.
- R5: Eight 32-bit payload words at offsets 0x20 to 0x3C read back what was written.
- R6: The pending register reads target AND NOT mask. Writing to target-clear clears the target bits set in the written value.
- R7: In the ready state, a start write whose value shares a bit with the owner makes the channel busy (status bit 6) and drives target AND NOT mask on the remote interrupt vector. A start write with no owner bit is ignored.
- R8: Status bit 0 holds the automatic-acknowledge selection, which is set by writing 1 to the status register. In that mode, an acknowledge pulse on a busy channel sets status bit 7, withdraws the remote interrupt and drives the owner vector on the local interrupt output.
- R9: In the acknowledged state, an ack-clear write that shares a bit with the owner returns the channel to ready and drops the local interrupt. A write with no owner bit is ignored.
- R10: With automatic acknowledge off, an acknowledge pulse on a busy channel returns it straight to ready, with no acknowledge bit and no local interrupt.
- R11: The interrupt outputs are the bitwise OR of all channels' contributions, and channels change state independently.
- R12: An address beyond the last channel, other than the lock address, reads 0, and a write to it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| remote_ack | input | NUM_CH | Per-channel acknowledge pulse from the remote side |
| remote_irq | output | VEC_W | Interrupt lines toward remote processors |
| local_irq | output | VEC_W | Interrupt lines toward local processors |

## Verification
The hardest situation to reach is two channels in flight at once in different acknowledge modes, because the OR-merged remote vector must lose exactly one channel's bits when only that channel is acknowledged. The stimulus brings there by walking channel 0 through a full automatic cycle. It then leaves channel 0 busy again and starts manual-mode channel 1 on a different line, and acknowledges only channel 1. A behavioural model in the bench predicts both interrupt vectors on every clock, so a mis-merged or mis-timed edge is caught in the cycle it happens.

// File: rtl/ipcmb_pkg.sv
package ipcmb_pkg;

   typedef enum logic [1:0] {
      CH_IDLE  = 2'd0,
      CH_READY = 2'd1,
      CH_BUSY  = 2'd2,
      CH_ACKED = 2'd3
   } ch_state_e;

   // word index inside a channel window (byte offset / 4)
   localparam logic [3:0] W_OWNER  = 4'd0;
   localparam logic [3:0] W_TARGET = 4'd1;
   localparam logic [3:0] W_TCLR   = 4'd2;
   localparam logic [3:0] W_PEND   = 4'd3;
   localparam logic [3:0] W_STATUS = 4'd4;
   localparam logic [3:0] W_MASK   = 4'd5;
   localparam logic [3:0] W_ACKCLR = 4'd6;
   localparam logic [3:0] W_START  = 4'd7;
   localparam logic [3:0] W_MSG0   = 4'd8;

   // status word bit positions
   localparam int ST_AUTO  = 0;
   localparam int ST_IDLE  = 4;
   localparam int ST_READY = 5;
   localparam int ST_BUSY  = 6;
   localparam int ST_ACK   = 7;

   localparam logic [31:0] OPEN_KEY = 32'h1ACC_E551;

endpackage

// File: rtl/ipcmb_keylock.sv
module ipcmb_keylock #(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned LOCK_ADDR = 'hA00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              locked_o
);
   import ipcmb_pkg::*;

   localparam logic [ADDR_W-1:0] L_ADDR = ADDR_W'(LOCK_ADDR);

   logic hit;
   assign hit = we_i && (addr_i == L_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   locked_o <= 1'b1;
      else if (hit) locked_o <= (wdata_i != OPEN_KEY[DATA_W-1:0]);
   end

   p_key_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && wdata_i == OPEN_KEY[DATA_W-1:0]) |=> !locked_o);
   p_bad_key_closes_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && wdata_i != OPEN_KEY[DATA_W-1:0]) |=> locked_o);
   p_lock_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> $stable(locked_o));

endmodule

// File: rtl/ipcmb_channel.sv
module ipcmb_channel #(
   parameter int unsigned VEC_W     = 8,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned MSG_WORDS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic              sel_i,
   input  logic              unlocked_i,
   input  logic [3:0]        word_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              remote_ack_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic [VEC_W-1:0]  remote_irq_o,
   output logic [VEC_W-1:0]  local_irq_o
);
   import ipcmb_pkg::*;

   ch_state_e         state_q;
   logic [VEC_W-1:0]  owner_q, target_q, mask_q;
   logic              auto_q;
   logic [DATA_W-1:0] msg_q [MSG_WORDS];

   logic             wr, release_w, owner_hit;
   logic [VEC_W-1:0] wvec;

   assign wr        = we_i && sel_i && unlocked_i;
   assign wvec      = wdata_i[VEC_W-1:0];
   assign release_w = wr && (word_i == W_OWNER) && (wvec == '0);
   assign owner_hit = |(wvec & owner_q);

   // channel state and ownership
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= CH_IDLE;
         owner_q <= '0;
      end else if (release_w) begin
         state_q <= CH_IDLE;
         owner_q <= '0;
      end else if (remote_ack_i && state_q == CH_BUSY) begin
         state_q <= auto_q ? CH_ACKED : CH_READY;
      end else if (wr) begin
         unique case (word_i)
            W_OWNER: if (state_q == CH_IDLE) begin
               owner_q <= wvec;
               state_q <= CH_READY;
            end
            W_START:  if (state_q == CH_READY && owner_hit) state_q <= CH_BUSY;
            W_ACKCLR: if (state_q == CH_ACKED && owner_hit) state_q <= CH_READY;
            default: ;
         endcase
      end
   end

   // configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         target_q <= '0;
         mask_q   <= '1;
         auto_q   <= 1'b0;
      end else if (wr) begin
         unique case (word_i)
            W_TARGET: target_q <= wvec;
            W_TCLR:   target_q <= target_q & ~wvec;
            W_MASK:   mask_q   <= wvec;
            W_STATUS: auto_q   <= wdata_i[0];
            default: ;
         endcase
      end
   end

   // payload words
   for (genvar gi = 0; gi < MSG_WORDS; gi++) begin : g_msg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                   msg_q[gi] <= '0;
         else if (wr && word_i == 4'(W_MSG0 + 4'(gi))) msg_q[gi] <= wdata_i;
      end
   end

   assign remote_irq_o = (state_q == CH_BUSY)  ? (target_q & ~mask_q) : '0;
   assign local_irq_o  = (state_q == CH_ACKED) ? owner_q : '0;

   always_comb begin
      rdata_o = '0;
      unique case (word_i)
         W_OWNER:  rdata_o[VEC_W-1:0] = owner_q;
         W_TARGET: rdata_o[VEC_W-1:0] = target_q;
         W_PEND:   rdata_o[VEC_W-1:0] = target_q & ~mask_q;
         W_MASK:   rdata_o[VEC_W-1:0] = mask_q;
         W_STATUS: begin
            rdata_o[ST_AUTO]  = auto_q;
            rdata_o[ST_IDLE]  = (state_q == CH_IDLE);
            rdata_o[ST_READY] = (state_q == CH_READY);
            rdata_o[ST_BUSY]  = (state_q == CH_BUSY);
            rdata_o[ST_ACK]   = (state_q == CH_ACKED);
         end
         default: begin
            for (int i = 0; i < MSG_WORDS; i++)
               if (word_i == 4'(W_MSG0 + 4'(i))) rdata_o = msg_q[i];
         end
      endcase
   end

   p_locked_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && sel_i && !unlocked_i) |=>
         ($stable(owner_q) && $stable(target_q) && $stable(mask_q) && $stable(auto_q)));
   p_claim_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && word_i == W_OWNER && wvec != '0 && state_q == CH_IDLE) |=>
         (state_q == CH_READY && owner_q == $past(wvec)));
   p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      release_w |=> (state_q == CH_IDLE && remote_irq_o == '0 && local_irq_o == '0));
   p_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && word_i == W_START && state_q == CH_READY && owner_hit) |=> state_q == CH_BUSY);
   p_autoack_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == CH_BUSY && remote_ack_i && auto_q && !release_w) |=>
         (local_irq_o == owner_q && remote_irq_o == '0));
   p_ackclr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == CH_ACKED && wr && word_i == W_ACKCLR && owner_hit) |=>
         (state_q == CH_READY && local_irq_o == '0));
   p_manual_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == CH_BUSY && remote_ack_i && !auto_q && !release_w) |=>
         (state_q == CH_READY && local_irq_o == '0));

endmodule

// File: rtl/ipcmb_irq_or.sv
module ipcmb_irq_or #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned VEC_W  = 8
) (
   input  logic [NUM_CH*VEC_W-1:0] vec_i,
   output logic [VEC_W-1:0]        vec_o
);
   always_comb begin
      vec_o = '0;
      for (int c = 0; c < NUM_CH; c++) vec_o |= vec_i[c*VEC_W +: VEC_W];
   end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
   parameter int unsigned NUM_CH    = 4,
   parameter int unsigned VEC_W     = 8,
   parameter int unsigned MSG_WORDS = 8,
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned LOCK_ADDR = 'hA00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NUM_CH-1:0] remote_ack,
   output logic [VEC_W-1:0]  remote_irq,
   output logic [VEC_W-1:0]  local_irq
);
   localparam int unsigned IDX_W = ADDR_W - 6;
   localparam logic [ADDR_W-1:0] L_ADDR = ADDR_W'(LOCK_ADDR);

   if (DATA_W != 32)               begin : g_bad_dw  $error("DATA_W must be 32"); end
   if (VEC_W < 1 || VEC_W > DATA_W) begin : g_bad_vw  $error("VEC_W out of range"); end
   if (MSG_WORDS < 1 || MSG_WORDS > 8) begin : g_bad_mw $error("MSG_WORDS must be 1..8"); end
   if (ADDR_W <= 6)                begin : g_bad_aw  $error("ADDR_W too small"); end
   if (NUM_CH * 64 > LOCK_ADDR)    begin : g_bad_lk  $error("lock overlaps channels"); end
   if (LOCK_ADDR >= (1 << ADDR_W)) begin : g_bad_la  $error("lock beyond address space"); end

   logic             locked;
   logic [IDX_W-1:0] ch_idx;
   logic             aligned;
   logic [NUM_CH-1:0] sel;
   logic [DATA_W-1:0] ch_rdata [NUM_CH];
   logic [NUM_CH*VEC_W-1:0] rirq_flat, lirq_flat;

   assign ch_idx  = bus_addr[ADDR_W-1:6];
   assign aligned = (bus_addr[1:0] == 2'b00);

   ipcmb_keylock #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOCK_ADDR(LOCK_ADDR)
   ) u_lock (
      .clk(clk), .rst_n(rst_n), .we_i(bus_we), .addr_i(bus_addr),
      .wdata_i(bus_wdata), .locked_o(locked)
   );

   for (genvar gc = 0; gc < NUM_CH; gc++) begin : g_ch
      assign sel[gc] = aligned && (ch_idx == IDX_W'(gc));
      ipcmb_channel #(
         .VEC_W(VEC_W), .DATA_W(DATA_W), .MSG_WORDS(MSG_WORDS)
      ) u_ch (
         .clk(clk), .rst_n(rst_n), .we_i(bus_we), .sel_i(sel[gc]),
         .unlocked_i(!locked), .word_i(bus_addr[5:2]), .wdata_i(bus_wdata),
         .remote_ack_i(remote_ack[gc]), .rdata_o(ch_rdata[gc]),
         .remote_irq_o(rirq_flat[gc*VEC_W +: VEC_W]),
         .local_irq_o(lirq_flat[gc*VEC_W +: VEC_W])
      );
   end

   ipcmb_irq_or #(.NUM_CH(NUM_CH), .VEC_W(VEC_W)) u_ror (.vec_i(rirq_flat), .vec_o(remote_irq));
   ipcmb_irq_or #(.NUM_CH(NUM_CH), .VEC_W(VEC_W)) u_lor (.vec_i(lirq_flat), .vec_o(local_irq));

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == L_ADDR) bus_rdata[0] = locked;
      else
         for (int c = 0; c < NUM_CH; c++) if (sel[c]) bus_rdata = ch_rdata[c];
   end

   p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(locked) |-> ($past(bus_we) && $past(bus_addr) == L_ADDR));
   p_sel_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel));

endmodule

// File: tb/sim_ipc_mailbox.sv
`timescale 1ns/1ps
module sim_ipc_mailbox;
   localparam int NCH = 4;
   localparam logic [31:0] KEY = 32'h1ACC_E551;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [NCH-1:0] remote_ack = '0;
   logic [7:0]  remote_irq, local_irq;

   int errors = 0;
   int checks = 0;

   always #2.5 clk = ~clk;

   ipc_mailbox u0 (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .remote_ack(remote_ack),
      .remote_irq(remote_irq), .local_irq(local_irq)
   );

   // behavioural reference: 0 idle, 1 ready, 2 busy, 3 acked
   int         m_st   [NCH];
   logic [7:0] m_own  [NCH];
   logic [7:0] m_tgt  [NCH];
   logic [7:0] m_msk  [NCH];
   bit         m_auto [NCH];
   bit         m_locked;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int c = 0; c < NCH; c++) begin
            m_st[c] = 0; m_own[c] = 0; m_tgt[c] = 0; m_msk[c] = 8'hFF; m_auto[c] = 0;
         end
         m_locked = 1;
      end else begin
         int ch, wd;
         bit wr;
         logic [7:0] v;
         ch = int'(bus_addr >> 6);
         wd = int'((bus_addr >> 2) & 12'hF);
         v  = bus_wdata[7:0];
         wr = bus_we && !m_locked && bus_addr[1:0] == 0 && ch < NCH;
         for (int c = 0; c < NCH; c++) begin
            bit mine;
            mine = wr && ch == c;
            if (mine && wd == 0 && v == 0) begin
               m_st[c] = 0; m_own[c] = 0;
            end else if (remote_ack[c] && m_st[c] == 2) begin
               m_st[c] = m_auto[c] ? 3 : 1;
            end else if (mine) begin
               if (wd == 0 && m_st[c] == 0) begin m_own[c] = v; m_st[c] = 1; end
               if (wd == 7 && m_st[c] == 1 && (v & m_own[c]) != 0) m_st[c] = 2;
               if (wd == 6 && m_st[c] == 3 && (v & m_own[c]) != 0) m_st[c] = 1;
            end
            if (mine && wd == 1) m_tgt[c] = v;
            if (mine && wd == 2) m_tgt[c] = m_tgt[c] & ~v;
            if (mine && wd == 5) m_msk[c] = v;
            if (mine && wd == 4) m_auto[c] = bus_wdata[0];
         end
         if (bus_we && bus_addr == 12'hA00) m_locked = (bus_wdata != KEY);
      end
   end

   function automatic logic [7:0] exp_rirq();
      logic [7:0] r = 0;
      for (int c = 0; c < NCH; c++) if (m_st[c] == 2) r |= m_tgt[c] & ~m_msk[c];
      return r;
   endfunction
   function automatic logic [7:0] exp_lirq();
      logic [7:0] r = 0;
      for (int c = 0; c < NCH; c++) if (m_st[c] == 3) r |= m_own[c];
      return r;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // every-clock comparison of both interrupt vectors (R7 R8 R10 R11)
   always @(negedge clk) if (rst_n) begin
      chk("R11 remote_irq vs model", {24'h0, remote_irq}, {24'h0, exp_rirq()});
      chk("R11 local_irq vs model",  {24'h0, local_irq},  {24'h0, exp_lirq()});
   end

   task automatic wr(logic [11:0] a, logic [31:0] d);
      @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1 bus_we = 0;
   endtask
   task automatic rd(string tag, logic [11:0] a, logic [31:0] exp);
      @(negedge clk); bus_addr = a; #1 chk(tag, bus_rdata, exp);
   endtask
   task automatic ack(int c);
      @(negedge clk); remote_ack[c] = 1;
      @(posedge clk); #1 remote_ack = '0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: run hung, actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1 reset state
      rd("R1 status idle",  12'h010, 32'h10);
      rd("R1 lock engaged", 12'hA00, 32'h1);
      rd("R1 mask all set", 12'h014, 32'hFF);
      rd("R1 target zero",  12'h004, 32'h0);
      chk("R1 irqs quiet", {remote_irq, local_irq}, 32'h0);
      // R2 locked writes ignored
      wr(12'h000, 32'h1);
      rd("R2 locked owner write ignored", 12'h000, 32'h0);
      wr(12'hA00, 32'h1234);
      rd("R2 wrong key keeps lock", 12'hA00, 32'h1);
      wr(12'hA00, KEY);
      rd("R2 key opens lock", 12'hA00, 32'h0);
      // R3 claim
      wr(12'h000, 32'h02);
      rd("R3 owner stored", 12'h000, 32'h02);
      rd("R3 ready",        12'h010, 32'h20);
      wr(12'h000, 32'h04);
      rd("R3 second claim ignored", 12'h000, 32'h02);
      // R5 payload
      for (int i = 0; i < 8; i++) wr(12'(32 + 4*i), 32'hC0DE_0000 + 32'(i * 'h111));
      for (int i = 0; i < 8; i++) rd("R5 payload word", 12'(32 + 4*i), 32'hC0DE_0000 + 32'(i * 'h111));
      // R6 target / mask / pending
      wr(12'h004, 32'h09);
      wr(12'h014, 32'hFE);
      rd("R6 pending", 12'h00C, 32'h01);
      wr(12'h008, 32'h08);
      rd("R6 target-clear", 12'h004, 32'h01);
      // R8 select auto mode, R7 start
      wr(12'h010, 32'h1);
      rd("R8 auto bit", 12'h010, 32'h21);
      wr(12'h01C, 32'h04);
      rd("R7 start without owner bit ignored", 12'h010, 32'h21);
      chk("R7 no remote irq", {24'h0, remote_irq}, 32'h0);
      wr(12'h01C, 32'h02);
      rd("R7 busy", 12'h010, 32'h41);
      chk("R7 remote irq line", {24'h0, remote_irq}, 32'h01);
      ack(0);
      rd("R8 acked", 12'h010, 32'h81);
      chk("R8 local irq owner", {24'h0, local_irq}, 32'h02);
      chk("R8 remote withdrawn", {24'h0, remote_irq}, 32'h0);
      // R9 ack-clear
      wr(12'h018, 32'h01);
      rd("R9 wrong bit ignored", 12'h010, 32'h81);
      wr(12'h018, 32'h02);
      rd("R9 back to ready", 12'h010, 32'h21);
      chk("R9 local irq dropped", {24'h0, local_irq}, 32'h0);
      // R11 / R10 two channels in flight, channel 1 manual
      wr(12'h040, 32'h10);
      wr(12'h044, 32'h04);
      wr(12'h054, 32'hFB);
      wr(12'h05C, 32'h10);
      wr(12'h01C, 32'h02);
      chk("R11 merged remote irq", {24'h0, remote_irq}, 32'h05);
      rd("R11 ch1 pending", 12'h04C, 32'h04);
      ack(1);
      rd("R10 manual ack to ready", 12'h050, 32'h20);
      chk("R10 no local irq", {24'h0, local_irq}, 32'h0);
      chk("R11 ch0 still busy", {24'h0, remote_irq}, 32'h01);
      // R4 release
      wr(12'h000, 32'h0);
      rd("R4 released idle", 12'h010, 32'h11);
      rd("R4 owner cleared", 12'h000, 32'h0);
      chk("R4 remote irq withdrawn", {24'h0, remote_irq}, 32'h0);
      // R12 out of range
      wr(12'h100, 32'h1);
      rd("R12 out-of-range reads zero", 12'h100, 32'h0);
      rd("R12 ch0 untouched", 12'h000, 32'h0);
      // R2 relock
      wr(12'hA00, 32'h0);
      rd("R2 relocked", 12'hA00, 32'h1);
      wr(12'h044, 32'hFF);
      rd("R2 write while relocked ignored", 12'h044, 32'h04);
      repeat (2) @(posedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule